// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block gathers event flags from a generator core into a single interrupt line, in two stages. In the first stage, three sticky core flags (completion, self-test fault and health-check fault) are each qualified by an enable bit. The qualified flags are ORed into a summary bit held in the top-level status word. The top-level status word also holds a bus-error flag. The interrupt line is driven from the top-level status word through a mask. Software cannot write the mask directly. It can only set mask bits through one write port and clear them through another.

Software clears core flags by writing self-clearing clear bits in the core control word. It clears top-level bits by writing ones to them. Event inputs are single-cycle pulses. The two fault events are accepted only while the entropy source is marked as running. A simple single-cycle register write port and an independent combinational read port give access to the registers.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the enables, all core flags and both top-level status bits are 0, the mask reads 0x3 and `irq` is low.
- R2: The control word (select 0) holds the completion enable in bit 0, the self-test enable in bit 1 and the health-check enable in bit 2. Bits 3, 4 and 5 of the same write are clear commands for those three flags. On read, bits 2:0 return the enables and every other bit returns 0.
- R3: The flag word (select 1) is read-only. It shows completion in bit 0, self-test fault in bit 1 and health-check fault in bit 3, and all other bits read 0. A control write with a clear bit at 1 clears the matching flag.
- R4: The summary bit (bit 0 of the top-level status, select 2) is reloaded with the OR over the three flags of (flag AND enable). The values used are the ones after the cycle's update. The reload happens on every control write and in every cycle that accepts an event. In other cycles the summary bit holds its value, unless it is cleared by writing a 1.
- R5: Top-level status bits 1:0 are write-one-to-clear. A written 0 leaves a bit unchanged.
- R6: The mask (select 3) ignores direct writes. A write to select 4 clears the written mask bits and a write to select 5 sets them. Selects 4 to 7 read as 0.
- R7: `irq` is a register. One clock edge after any change, it equals the OR of (top-level status bit AND NOT mask bit) over both bits.
- R8: While `src_on` is low, self-test and health-check fault events are ignored. Completion events are still accepted.
- R9: When an event and a clear command hit the same flag in the same cycle, the flag ends up set.
- R10: A pulse on `ev_bus_err` sets bit 1 of the top-level status. If it arrives in the same cycle as a write-one-to-clear of that bit, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | AW | Register select for the write |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Register select for the read |
| rd_data | output | DW | Combinational read data |
| ev_done | input | 1 | Completion event pulse |
| ev_dtf | input | 1 | Self-test fault event pulse |
| ev_certf | input | 1 | Health-check fault event pulse |
| ev_bus_err | input | 1 | Bus-error event pulse |
| src_on | input | 1 | Entropy source running; gates the fault events |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every input changes only between clock edges and is stable at each rising edge. They also assume that `wr_data` bits above 5 carry no meaning. Both the mask-port checks and the fault-gating checks compare state against the inputs of the previous cycle. The stimulus therefore holds each input for a whole cycle and drives it only at the falling edge. Random traffic spans all eight selects and mixes events with writes freely, so that clear-and-set collisions happen often. Directed sequences force the collision, gating and masking corners.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          ev_done,
  input  logic          ev_dtf,
  input  logic          ev_certf,
  input  logic          ev_bus_err,
  input  logic          src_on,
  output logic          irq
);
  localparam int NFLAG = 3;
  localparam int NTOP  = 2;
  localparam logic [AW-1:0] SEL_CTL  = AW'(0);
  localparam logic [AW-1:0] SEL_FLG  = AW'(1);
  localparam logic [AW-1:0] SEL_TOP  = AW'(2);
  localparam logic [AW-1:0] SEL_MSK  = AW'(3);
  localparam logic [AW-1:0] SEL_UNM  = AW'(4);
  localparam logic [AW-1:0] SEL_SETM = AW'(5);

  logic [NFLAG-1:0] en_q, flag_q, en_d, flag_d, flag_set, flag_clr;
  logic [NTOP-1:0]  top_q, mask_q, top_d, mask_d, top_w1c;
  logic             recalc;

  wire ctl_wr  = wr_en && (wr_addr == SEL_CTL);
  wire top_wr  = wr_en && (wr_addr == SEL_TOP);
  wire unm_wr  = wr_en && (wr_addr == SEL_UNM);
  wire setm_wr = wr_en && (wr_addr == SEL_SETM);
  wire unused_wdata = ^wr_data[DW-1:2*NFLAG];

  assign flag_set = {ev_certf & src_on, ev_dtf & src_on, ev_done};
  assign flag_clr = ctl_wr ? wr_data[2*NFLAG-1:NFLAG] : '0;
  assign flag_d   = (flag_q & ~flag_clr) | flag_set;
  assign en_d     = ctl_wr ? wr_data[NFLAG-1:0] : en_q;
  assign recalc   = ctl_wr | (|flag_set);
  assign top_w1c  = top_wr ? wr_data[NTOP-1:0] : '0;

  assign top_d[0] = recalc ? |(flag_d & en_d) : (top_q[0] & ~top_w1c[0]);
  assign top_d[1] = ev_bus_err | (top_q[1] & ~top_w1c[1]);

  always_comb begin
    mask_d = mask_q;
    if (unm_wr)       mask_d = mask_q & ~wr_data[NTOP-1:0];
    else if (setm_wr) mask_d = mask_q | wr_data[NTOP-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      flag_q <= '0;
      top_q  <= '0;
      mask_q <= '1;
      irq    <= 1'b0;
    end else begin
      en_q   <= en_d;
      flag_q <= flag_d;
      top_q  <= top_d;
      mask_q <= mask_d;
      irq    <= |(top_d & ~mask_d);
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      SEL_CTL: rd_data[NFLAG-1:0] = en_q;
      SEL_FLG: begin
        rd_data[0] = flag_q[0];
        rd_data[1] = flag_q[1];
        rd_data[3] = flag_q[2];
      end
      SEL_TOP: rd_data[NTOP-1:0] = top_q;
      SEL_MSK: rd_data[NTOP-1:0] = mask_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic [AW-1:0] rd_addr,
  input logic [DW-1:0] rd_data,
  input logic          ev_done,
  input logic          ev_bus_err,
  input logic          src_on,
  input logic [2:0]    flag_q,
  input logic [1:0]    top_q,
  input logic [1:0]    mask_q,
  input logic          irq
);
  wire ctl_w = wr_en && (wr_addr == AW'(0));
  wire unm_w = wr_en && (wr_addr == AW'(4));
  wire set_w = wr_en && (wr_addr == AW'(5));

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(top_q & ~mask_q)); // R7
  AST_UNMASK_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    unm_w |=> ((mask_q & $past(wr_data[1:0])) == 2'b00)); // R6
  AST_SETMASK_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    set_w |=> ((mask_q & $past(wr_data[1:0])) == $past(wr_data[1:0]))); // R6
  AST_FAULT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_on && !ctl_w) |=> (!$rose(flag_q[1]) && !$rose(flag_q[2]))); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> flag_q[0]); // R9
  AST_BUSERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_err |=> top_q[1]); // R10
  AST_CTL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == AW'(0)) |-> (rd_data[5:3] == 3'b000)); // R2
endmodule

bind irq_aggregator irq_aggregator_chk #(.DW(DW), .AW(AW)) chk_i (.*);

// File: tb/irq_aggregator_tb_top.sv
`timescale 1ns/1ps
module irq_aggregator_tb_top;
  localparam int CLK_P = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic ev_done = 0, ev_dtf = 0, ev_certf = 0, ev_bus_err = 0, src_on = 1;
  logic irq;
  int total = 0, bad = 0;

  logic [2:0] m_en, m_flag;
  logic [1:0] m_top, m_mask;
  logic m_irq;

  always #(CLK_P/2) clk = ~clk;

  irq_aggregator dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .ev_done(ev_done),
    .ev_dtf(ev_dtf), .ev_certf(ev_certf), .ev_bus_err(ev_bus_err), .src_on(src_on),
    .irq(irq));

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    logic [31:0] v = '0;
    case (a)
      3'd0: v[2:0] = m_en;
      3'd1: begin v[0] = m_flag[0]; v[1] = m_flag[1]; v[3] = m_flag[2]; end
      3'd2: v[1:0] = m_top;
      3'd3: v[1:0] = m_mask;
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic step(input logic we, input logic [2:0] wa, input logic [31:0] wd,
                      input logic e0, input logic e1, input logic e2, input logic eb,
                      input logic so);
    logic [2:0] set, clr, f, en;
    logic [1:0] w1c, t, mk;
    logic rc;
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd;
    ev_done = e0; ev_dtf = e1; ev_certf = e2; ev_bus_err = eb; src_on = so;
    set = {e2 & so, e1 & so, e0};
    clr = (we && wa == 3'd0) ? wd[5:3] : 3'b0;
    f   = (m_flag & ~clr) | set;
    en  = (we && wa == 3'd0) ? wd[2:0] : m_en;
    rc  = (we && wa == 3'd0) || (set != 3'b0);
    w1c = (we && wa == 3'd2) ? wd[1:0] : 2'b0;
    t[0] = rc ? |(f & en) : (m_top[0] & ~w1c[0]);
    t[1] = eb | (m_top[1] & ~w1c[1]);
    mk = m_mask;
    if (we && wa == 3'd4) mk = m_mask & ~wd[1:0];
    if (we && wa == 3'd5) mk = m_mask | wd[1:0];
    @(posedge clk);
    m_flag = f; m_en = en; m_top = t; m_mask = mk; m_irq = |(t & ~mk);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, src_on);
  endtask

  task automatic chk(input string req, input logic [2:0] a);
    rd_addr = a;
    #1;
    total++;
    if (rd_data !== exp_rd(a)) begin
      bad++;
      $display("FAIL %s sel=%0d actual=%h expected=%h", req, a, rd_data, exp_rd(a));
    end
  endtask

  task automatic chk_irq(input string req);
    #1;
    total++;
    if (irq !== m_irq) begin
      bad++;
      $display("FAIL %s irq actual=%b expected=%b", req, irq, m_irq);
    end
  endtask

  task automatic chk_all(input string req);
    for (int a = 0; a < 6; a++) chk(req, 3'(a));
    chk_irq(req);
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    string tag;
    void'($urandom(32'h5eed_1234));
    m_en = 0; m_flag = 0; m_top = 0; m_mask = 2'b11; m_irq = 0;
    #(CLK_P * 3);
    #3 chk_all("R1");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #1 chk_all("R1");

    // R6: direct mask write ignored, then unmask both
    step(1, 3'd3, 32'h0, 0, 0, 0, 0, 1); chk("R6", 3'd3);
    step(1, 3'd4, 32'h3, 0, 0, 0, 0, 1); chk("R6", 3'd3); chk("R6", 3'd4);
    // R4: enable completion, fire event, summary and irq rise
    step(1, 3'd0, 32'h1, 0, 0, 0, 0, 1); chk("R2", 3'd0);
    step(0, 0, 0, 1, 0, 0, 0, 1); chk("R4", 3'd2); chk_irq("R7");
    // R4: disabling the enable recomputes the summary to 0
    step(1, 3'd0, 32'h0, 0, 0, 0, 0, 1); chk("R4", 3'd2); chk_irq("R7");
    // R9: clear and event on the same flag
    step(1, 3'd0, 32'h9, 1, 0, 0, 0, 1); chk("R9", 3'd1); chk("R4", 3'd2);
    // R3: clear all flags
    step(1, 3'd0, 32'h38, 0, 0, 0, 0, 1); chk("R3", 3'd1);
    // R8: faults ignored while source stopped, completion still taken
    step(0, 0, 0, 1, 1, 1, 0, 0); chk("R8", 3'd1);
    step(0, 0, 0, 0, 1, 1, 0, 1); chk("R3", 3'd1);
    // R10 and R5: bus error set, collide with clear, then clear
    step(0, 0, 0, 0, 0, 0, 1, 1); chk("R10", 3'd2); chk_irq("R7");
    step(1, 3'd2, 32'h2, 0, 0, 0, 1, 1); chk("R10", 3'd2);
    step(1, 3'd2, 32'h1, 0, 0, 0, 0, 1); chk("R5", 3'd2);
    step(1, 3'd2, 32'h2, 0, 0, 0, 0, 1); chk("R5", 3'd2); chk_irq("R7");
    step(1, 3'd5, 32'h2, 0, 0, 0, 1, 1); chk("R6", 3'd3); chk_irq("R7");

    for (int i = 0; i < 600; i++) begin
      logic [2:0] wa;
      wa = 3'($urandom_range(0, 7));
      step(($urandom % 2) == 1, wa, $urandom, ($urandom % 5) == 0, ($urandom % 6) == 0,
           ($urandom % 6) == 0, ($urandom % 8) == 0, ($urandom % 4) != 0);
      for (int a = 0; a < 8; a++) begin
        case (a)
          0: tag = "R2"; 1: tag = "R3"; 2: tag = "R5"; default: tag = "R6";
        endcase
        chk(tag, 3'(a));
      end
      chk_irq("R7");
    end
    idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule